// File: doc/BRIEF.md
# Two-Winding Stepper Excitation Sequencer

This block turns a step clock into winding commands for a two-phase stepper motor. A six-bit phase position covers one electrical cycle in 64 fine positions. Each accepted step moves that position by one grid unit of the selected excitation mode. For each winding the block outputs a polarity bit and a current level in percent of the set current. The downstream current chopper uses these values as its target.

Five excitation modes share the one position register: full step, half step, quarter, eighth and sixteenth step. The position is never cleared on a mode change, so the motor keeps its electrical angle. An edge-select input chooses whether the step clock advances the position on rising edges only or on both edges. The same input also picks which group of four modes the two mode-select bits address. An enable input freezes sequencing and turns both windings off. A monitor output goes high whenever the position, taken on the current mode's grid, is at the electrical home position.

Top module: `stepper_phase_seq`

## Requirements
- R1: While rst_n is low, both winding levels and both polarities are 0 and home_mon is 1. The phase position is at home (0).
- R2: With rise_only=1, the position moves only on rising edges of step_in. With rise_only=0, it moves on both rising and falling edges.
- R3: With dir_ccw=0, a step adds one grid unit to the position modulo 64. With dir_ccw=1, a step subtracts one unit.
- R4: The grid unit is 16, 8, 4, 2 or 1 positions. With rise_only=1, mode_sel 0,1,2,3 select units 16, 8, 4 and 2. With rise_only=0, they select 8, 4, 2 and 1. The output position is the phase position with its bits below the unit cleared. A step moves from that cleared value.
- R5: For table shapes, let p be the output position, quadrant k = p[5:4] and q = p[3:0]. Winding A uses index 16-q when k is even and q when k is odd. Winding B uses q when k is even and 16-q when k is odd. The level for index 0..16 is 0,11,20,30,40,47,55,64,71,77,83,87,93,95,97,100,100. No level exceeds 100.
- R6: Half step with rise_only=1 drives every non-zero table entry at 100. Half step with rise_only=0 uses the table, so the diagonal positions drive 71 on both windings.
- R7: Full step (rise_only=1, mode_sel=0) drives both windings at 100.
- R8: A polarity output of 1 means positive drive. Winding A is positive in quadrants 0 and 3, and winding B in quadrants 0 and 1. Changing the mode or the edge select does not change the stored phase. Returning to a finer mode without a step restores the fine position.
- R9: One clock after enable is low, both levels and both polarities are 0. While enable is low, step edges do not move the position, and no step appears after enable returns.
- R10: home_mon is 1 exactly when the output position is 0. This holds regardless of enable.
- R11: With two synchronizer stages, a step_in change made between clock edges shows on the outputs after the third rising clock edge, and not after the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_in | input | 1 | Asynchronous step clock |
| dir_ccw | input | 1 | 0 = forward, 1 = reverse |
| mode_sel | input | 2 | Excitation mode select |
| rise_only | input | 1 | 1 = rising edges only, 0 = both edges |
| enable | input | 1 | 0 = windings off, sequencing frozen |
| a_pos | output | 1 | Winding A polarity, 1 = positive |
| a_level | output | 7 | Winding A current level in percent |
| b_pos | output | 1 | Winding B polarity, 1 = positive |
| b_level | output | 7 | Winding B current level in percent |
| home_mon | output | 1 | High at the electrical home position |

## Verification
The bench walks a whole 64-position cycle in sixteenth mode, which exposes any wrong table entry, quadrant mirror or winding swap. It then steps backwards across the wrap from 0 to 63, where an unsigned or unwrapped counter would land on the wrong side. Mode switches from an odd fine position to a coarse grid and back would show a design that clears or rounds the stored position instead of masking the output. Steps given while disabled would reveal an edge detector that counts a stale edge after enable returns. Exact-cycle sampling around the synchronizer catches a pipeline that is one stage too short or too long.

// File: rtl/stp_pkg.sv
package stp_pkg;

    localparam int PH_W  = 6;
    localparam int QTR_W = 4;
    localparam int IDX_W = QTR_W + 1;
    localparam int LVL_W = 7;
    localparam logic [LVL_W-1:0] LVL_MAX = LVL_W'(100);

    typedef enum logic [1:0] {
        SHAPE_FULL  = 2'd0,
        SHAPE_FLAT  = 2'd1,
        SHAPE_TABLE = 2'd2
    } shape_e;

    typedef struct packed {
        logic [2:0] shift;
        shape_e     shape;
    } mode_cfg_t;

    typedef struct packed {
        logic [PH_W-1:0]  phase;
        logic             a_pos;
        logic [LVL_W-1:0] a_lvl;
        logic             b_pos;
        logic [LVL_W-1:0] b_lvl;
        logic             mon;
    } seq_state_t;

    // Grid unit is 1 << shift; rising-only mode sets sit one octave coarser.
    function automatic mode_cfg_t decode_mode(input logic rise_only,
                                              input logic [1:0] sel);
        mode_cfg_t c;
        c.shift = rise_only ? 3'(3'd4 - {1'b0, sel}) : 3'(3'd3 - {1'b0, sel});
        if (rise_only && sel == 2'd0) begin
            c.shape = SHAPE_FULL;
        end else if (rise_only && sel == 2'd1) begin
            c.shape = SHAPE_FLAT;
        end else begin
            c.shape = SHAPE_TABLE;
        end
        return c;
    endfunction

    // Quarter-wave current profile in percent, index 0..16.
    function automatic logic [LVL_W-1:0] quarter_level(input logic [IDX_W-1:0] idx);
        logic [LVL_W-1:0] v;
        case (idx)
            5'd0:    v = 7'd0;
            5'd1:    v = 7'd11;
            5'd2:    v = 7'd20;
            5'd3:    v = 7'd30;
            5'd4:    v = 7'd40;
            5'd5:    v = 7'd47;
            5'd6:    v = 7'd55;
            5'd7:    v = 7'd64;
            5'd8:    v = 7'd71;
            5'd9:    v = 7'd77;
            5'd10:   v = 7'd83;
            5'd11:   v = 7'd87;
            5'd12:   v = 7'd93;
            5'd13:   v = 7'd95;
            5'd14:   v = 7'd97;
            default: v = 7'd100;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/stp_step_edge.sv
module stp_step_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step_in,
    input  logic rise_only,
    output logic step_evt
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   last;
    } edge_state_t;

    edge_state_t st_q, st_d;
    logic        synced;

    always_comb begin
        st_d      = st_q;
        st_d.sync = SYNC_STAGES'({st_q.sync, step_in});
        st_d.last = st_q.sync[SYNC_STAGES-1];
        synced    = st_q.sync[SYNC_STAGES-1];
        step_evt  = (synced & ~st_q.last) | (~rise_only & ~synced & st_q.last);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/stp_winding_map.sv
module stp_winding_map
    import stp_pkg::*;
#(
    parameter bit IS_B = 1'b0
) (
    input  logic [PH_W-1:0]  pq,
    input  shape_e           shape,
    input  logic             enable,
    output logic             pos,
    output logic [LVL_W-1:0] level
);

    logic [1:0]       quad;
    logic [QTR_W-1:0] frac;
    logic [IDX_W-1:0] rise_idx;
    logic [IDX_W-1:0] fall_idx;
    logic [IDX_W-1:0] idx;
    logic             raw_pos;
    logic [LVL_W-1:0] raw_lvl;

    always_comb begin
        quad     = pq[PH_W-1:QTR_W];
        frac     = pq[QTR_W-1:0];
        rise_idx = {1'b0, frac};
        fall_idx = IDX_W'(5'd16 - {1'b0, frac});
        if (IS_B) begin
            idx     = quad[0] ? fall_idx : rise_idx;
            raw_pos = ~quad[1];
        end else begin
            idx     = quad[0] ? rise_idx : fall_idx;
            raw_pos = (quad[1] == quad[0]);
        end
        case (shape)
            SHAPE_FULL: raw_lvl = LVL_MAX;
            SHAPE_FLAT: raw_lvl = (idx != '0) ? LVL_MAX : '0;
            default:    raw_lvl = quarter_level(idx);
        endcase
        pos   = enable ? raw_pos : 1'b0;
        level = enable ? raw_lvl : '0;
    end

endmodule

// File: rtl/stepper_phase_seq.sv
module stepper_phase_seq
    import stp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_in,
    input  logic             dir_ccw,
    input  logic [1:0]       mode_sel,
    input  logic             rise_only,
    input  logic             enable,
    output logic             a_pos,
    output logic [LVL_W-1:0] a_level,
    output logic             b_pos,
    output logic [LVL_W-1:0] b_level,
    output logic             home_mon
);

    localparam int NUM_WIND = 2;

    seq_state_t       st_q, st_d;
    mode_cfg_t        cfg;
    logic             step_evt;
    logic [PH_W-1:0]  unit;
    logic [PH_W-1:0]  grid_mask;
    logic [PH_W-1:0]  pq_cur;
    logic [PH_W-1:0]  pq_next;
    logic [NUM_WIND-1:0] w_pos;
    logic [LVL_W-1:0] w_lvl [NUM_WIND];

    stp_step_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_in   (step_in),
        .rise_only (rise_only),
        .step_evt  (step_evt)
    );

    for (genvar w = 0; w < NUM_WIND; w++) begin : g_wind
        stp_winding_map #(.IS_B(w == 1)) u_map (
            .pq     (pq_next),
            .shape  (cfg.shape),
            .enable (enable),
            .pos    (w_pos[w]),
            .level  (w_lvl[w])
        );
    end

    always_comb begin
        cfg       = decode_mode(rise_only, mode_sel);
        unit      = PH_W'(1) << cfg.shift;
        grid_mask = ~(unit - PH_W'(1));
        pq_cur    = st_q.phase & grid_mask;
        st_d      = st_q;
        if (enable && step_evt) begin
            st_d.phase = dir_ccw ? (pq_cur - unit) : (pq_cur + unit);
        end
        pq_next    = st_d.phase & grid_mask;
        st_d.a_pos = w_pos[0];
        st_d.a_lvl = w_lvl[0];
        st_d.b_pos = w_pos[1];
        st_d.b_lvl = w_lvl[1];
        st_d.mon   = (pq_next == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.mon <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign a_pos    = st_q.a_pos;
    assign a_level  = st_q.a_lvl;
    assign b_pos    = st_q.b_pos;
    assign b_level  = st_q.b_lvl;
    assign home_mon = st_q.mon;

endmodule

// File: rtl/stepper_phase_seq_chk.sv
module stepper_phase_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode_sel,
    input logic       rise_only,
    input logic       enable,
    input logic       a_pos,
    input logic [6:0] a_level,
    input logic       b_pos,
    input logic [6:0] b_level,
    input logic       home_mon
);

    assert_off_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (a_level == 7'd0 && b_level == 7'd0 && !a_pos && !b_pos));

    assert_frozen_monitor_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && $past(!enable) && $stable(mode_sel) && $stable(rise_only))
        |=> $stable(home_mon));

    assert_full_step_levels_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && rise_only && mode_sel == 2'd0)
        |=> (a_level == 7'd100 && b_level == 7'd100));

    assert_home_levels_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !(rise_only && mode_sel == 2'd0))
        |=> (!home_mon || (a_level == 7'd100 && b_level == 7'd0 && a_pos)));

    assert_level_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (a_level <= 7'd100 && b_level <= 7'd100));

endmodule

bind stepper_phase_seq stepper_phase_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_sel  (mode_sel),
    .rise_only (rise_only),
    .enable    (enable),
    .a_pos     (a_pos),
    .a_level   (a_level),
    .b_pos     (b_pos),
    .b_level   (b_level),
    .home_mon  (home_mon)
);

// File: tb/stepper_phase_seq_test.sv
module stepper_phase_seq_test;

    localparam int CLK_P = 10;
    localparam int RAND_ITERS = 300;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       step_in;
    logic       dir_ccw;
    logic [1:0] mode_sel;
    logic       rise_only;
    logic       enable;
    logic       a_pos;
    logic [6:0] a_level;
    logic       b_pos;
    logic [6:0] b_level;
    logic       home_mon;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int m_phase = 0;

    stepper_phase_seq uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_in   (step_in),
        .dir_ccw   (dir_ccw),
        .mode_sel  (mode_sel),
        .rise_only (rise_only),
        .enable    (enable),
        .a_pos     (a_pos),
        .a_level   (a_level),
        .b_pos     (b_pos),
        .b_level   (b_level),
        .home_mon  (home_mon)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic int unit_of(bit ro, int sel);
        return 1 << (ro ? (4 - sel) : (3 - sel));
    endfunction

    function automatic int tab(int idx);
        case (idx)
            0: return 0;    1: return 11;   2: return 20;   3: return 30;
            4: return 40;   5: return 47;   6: return 55;   7: return 64;
            8: return 71;   9: return 77;   10: return 83;  11: return 87;
            12: return 93;  13: return 95;  14: return 97;
            default: return 100;
        endcase
    endfunction

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic check_val(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Expected outputs derived from requirements R4..R10
    task automatic check_all(input string tag);
        int u, pq, k, q, ia, ib, ea, eb, pa, pb;
        u  = unit_of(rise_only, int'(mode_sel));
        pq = m_phase & ~(u - 1) & 63;
        k  = pq >> 4;
        q  = pq & 15;
        ia = (k % 2 == 0) ? 16 - q : q;
        ib = (k % 2 == 0) ? q : 16 - q;
        pa = (k == 0 || k == 3) ? 1 : 0;
        pb = (k == 0 || k == 1) ? 1 : 0;
        if (rise_only && mode_sel == 2'd0) begin
            ea = 100; eb = 100;
        end else if (rise_only && mode_sel == 2'd1) begin
            ea = (ia != 0) ? 100 : 0;
            eb = (ib != 0) ? 100 : 0;
        end else begin
            ea = tab(ia); eb = tab(ib);
        end
        if (!enable) begin
            ea = 0; eb = 0; pa = 0; pb = 0;
        end
        check_val({tag, " a_level"}, int'(a_level), ea);
        check_val({tag, " b_level"}, int'(b_level), eb);
        check_val({tag, " a_pos"},   int'(a_pos),   pa);
        check_val({tag, " b_pos"},   int'(b_pos),   pb);
        check_val({tag, " home_mon"}, int'(home_mon), (pq == 0) ? 1 : 0);
    endtask

    task automatic model_step(input bit new_val);
        int u, pq;
        if (!enable) return;
        if (rise_only && !new_val) return;
        u  = unit_of(rise_only, int'(mode_sel));
        pq = m_phase & ~(u - 1) & 63;
        m_phase = dir_ccw ? ((pq - u) & 63) : ((pq + u) & 63);
    endtask

    task automatic toggle();
        @(negedge clk);
        step_in = ~step_in;
        model_step(step_in);
        repeat (4) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_cfg(input bit ro, input int sel, input bit dir, input bit en);
        @(negedge clk);
        rise_only = ro;
        mode_sel  = 2'(sel);
        dir_ccw   = dir;
        enable    = en;
        repeat (2) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            errors++;
            $display("FAIL R11 watchdog: actual running expected finished");
            report();
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        rst_n = 1'b0; step_in = 1'b0; dir_ccw = 1'b0;
        mode_sel = 2'd3; rise_only = 1'b0; enable = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check_val("R1 reset a_level", int'(a_level), 0);
        check_val("R1 reset b_level", int'(b_level), 0);
        check_val("R1 reset a_pos", int'(a_pos), 0);
        check_val("R1 reset home_mon", int'(home_mon), 1);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check_val("R10 home a_level", int'(a_level), 100);
        check_all("R10 home");

        // R11 exact latency, sixteenth step
        step_in = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check_val("R11 not before third edge b_level", int'(b_level), 0);
        model_step(1'b1);
        @(posedge clk);
        @(negedge clk);
        check_val("R11 at third edge b_level", int'(b_level), 11);
        check_all("R11");
        repeat (2) @(posedge clk);

        // R2 falling edge counts with rise_only=0
        toggle();
        check_val("R2 both edges a_level", int'(a_level), 97);
        check_val("R2 both edges b_level", int'(b_level), 20);

        // R5 full table walk
        for (int i = 0; i < 62; i++) begin
            toggle();
            check_all("R5 walk");
        end
        check_val("R10 cycle wrap home_mon", int'(home_mon), 1);

        // R3 reverse across wrap
        set_cfg(1'b0, 3, 1'b1, 1'b1);
        toggle();
        check_val("R3 reverse b_level", int'(b_level), 11);
        check_val("R3 reverse b_pos", int'(b_pos), 0);
        check_val("R3 reverse a_level", int'(a_level), 100);

        // R4 / R8 mode change keeps phase
        set_cfg(1'b0, 2, 1'b1, 1'b1);
        check_val("R4 eighth grid a_level", int'(a_level), 97);
        check_val("R4 eighth grid b_level", int'(b_level), 20);
        set_cfg(1'b0, 3, 1'b1, 1'b1);
        check_val("R8 restore a_level", int'(a_level), 100);
        check_val("R8 restore b_level", int'(b_level), 11);

        // R7 full step
        set_cfg(1'b1, 0, 1'b0, 1'b1);
        check_val("R7 full a_level", int'(a_level), 100);
        check_val("R7 full b_level", int'(b_level), 100);
        check_val("R8 quadrant3 a_pos", int'(a_pos), 1);
        check_val("R8 quadrant3 b_pos", int'(b_pos), 0);
        toggle();
        check_val("R2 falling ignored b_pos", int'(b_pos), 0);
        toggle();
        check_val("R7 full step b_pos", int'(b_pos), 1);
        check_val("R7 full step home_mon", int'(home_mon), 1);

        // R6 half step flat vs pseudo-micro
        set_cfg(1'b1, 1, 1'b0, 1'b1);
        check_val("R6 flat home b_level", int'(b_level), 0);
        toggle();
        toggle();
        check_val("R6 flat diag a_level", int'(a_level), 100);
        check_val("R6 flat diag b_level", int'(b_level), 100);
        set_cfg(1'b0, 0, 1'b0, 1'b1);
        check_val("R6 pseudo a_level", int'(a_level), 71);
        check_val("R6 pseudo b_level", int'(b_level), 71);

        // R9 enable low
        set_cfg(1'b0, 0, 1'b0, 1'b0);
        check_val("R9 off a_level", int'(a_level), 0);
        check_val("R9 off b_level", int'(b_level), 0);
        toggle();
        toggle();
        toggle();
        check_all("R9 frozen");
        set_cfg(1'b0, 0, 1'b0, 1'b1);
        check_val("R9 resume a_level", int'(a_level), 71);
        check_val("R9 resume b_level", int'(b_level), 71);

        // Random mix: R2 R3 R4 R5 R6 R7 R8 R9 R10
        for (int i = 0; i < RAND_ITERS; i++) begin
            @(negedge clk);
            rise_only = 1'($urandom % 2);
            mode_sel  = 2'($urandom % 4);
            dir_ccw   = 1'($urandom % 2);
            enable    = ($urandom % 8) != 0;
            step_in   = ~step_in;
            model_step(step_in);
            repeat (4) @(posedge clk);
            @(negedge clk);
            check_all("R2 R3 R4 R8 random");
        end

        done = 1;
        report();
    end

endmodule